// File: doc/BRIEF.md
# Coarse-Grain Two-Thread Switch Controller

This block picks which of two hardware thread contexts owns a short in-order pipeline. One context is the preferred thread and runs whenever it can. When the running thread reports a long-latency miss, the controller records it as pending, stores the PC of that thread's oldest unretired instruction, and, if the other thread is free, hands the pipeline over. A handover means a one-cycle flush of every in-flight instruction and a fetch redirect to the incoming thread's stored PC. When the preferred thread's miss comes back, control returns to it the same way.

Miss and miss-return events come from the memory side, each tagged with a thread ID. If both threads are waiting on memory the controller does not switch and leaves the current thread in place. A return and a new miss seen in one cycle are applied return first, then miss, before the switch decision is made. Register files, caches and the pipeline itself sit outside the block.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After reset the active thread is the preferred thread (ID 0 by default), no miss is pending, and flush_o and redirect_valid_o are 0.
- R2: A miss tagged with the active preferred thread, while the other thread (ID 1) has no pending miss, makes active_tid_o become 1 one cycle after the event, with flush_o and redirect_valid_o high in that cycle.
- R3: A miss-return for the preferred thread, while thread 1 is running, makes active_tid_o become the preferred ID one cycle later with a flush and a redirect to the PC given with that thread's last accepted miss.
- R4: flush_o and redirect_valid_o are high together and only in the cycle right after a switch decision; in every cycle without a switch both are 0 and active_tid_o is unchanged.
- R5: Each thread's saved PC persists across switches: a redirect to a thread always carries the miss PC last accepted for that thread.
- R6: While both threads have a pending miss, no switch, flush or redirect takes place.
- R7: A return and a miss arriving in the same cycle are applied return first; a return for thread 1 together with a new miss of the running preferred thread switches to thread 1.
- R8: A miss tagged with a thread that is not active, or with a thread whose miss is already pending, is ignored: no switch occurs and its PC is not stored.
- R9: The first redirect to thread 1 carries the parameter ALT_BOOT_PC (default 0x0000_2000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | Long-latency miss event |
| miss_tid_i | input | 1 | Thread that missed |
| miss_pc_i | input | PC_W | PC of that thread's oldest unretired instruction |
| ret_valid_i | input | 1 | Miss-return event |
| ret_tid_i | input | 1 | Thread whose miss returned |
| active_tid_o | output | 1 | Thread currently owning the pipeline |
| flush_o | output | 1 | One-cycle flush of in-flight instructions |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | PC_W | Fetch redirect target |

## Verification
The hardest case to reach is the same-cycle return of thread 1 with a fresh miss of the preferred thread, because it needs thread 1 to be pending while the preferred thread runs. The stimulus gets there by letting the preferred thread miss, making thread 1 miss while it stands in so both are pending, returning the preferred thread, and only then firing the combined event. The both-pending hold and the ignored stray misses are also checked at the outputs on the cycle after each event.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;
  localparam int unsigned NUM_THR = 2;
  localparam int unsigned TID_W   = 1;
  typedef logic [TID_W-1:0] tid_t;
endpackage

// File: rtl/cgmt_miss_track.sv
module cgmt_miss_track
  import cgmt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_valid_i,
  input  tid_t               miss_tid_i,
  input  logic               ret_valid_i,
  input  tid_t               ret_tid_i,
  input  tid_t               active_tid_i,
  output logic [NUM_THR-1:0] pend_next_o,
  output logic [NUM_THR-1:0] miss_take_o
);
  logic [NUM_THR-1:0] pend_q;
  logic [NUM_THR-1:0] pend_clr;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    // return is applied before miss
    assign pend_clr[t]    = pend_q[t] & ~(ret_valid_i && ret_tid_i == tid_t'(t));
    assign miss_take_o[t] = miss_valid_i && miss_tid_i == tid_t'(t) &&
                            active_tid_i == tid_t'(t) && !pend_clr[t];
    assign pend_next_o[t] = pend_clr[t] | miss_take_o[t];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[t] <= 1'b0;
      else         pend_q[t] <= pend_next_o[t];
    end
  end
endmodule

// File: rtl/cgmt_ctx_pc.sv
module cgmt_ctx_pc
  import cgmt_pkg::*;
#(
  parameter int unsigned PC_W         = 32,
  parameter int unsigned PREF_TID     = 0,
  parameter logic [PC_W-1:0] PREF_BOOT_PC = '0,
  parameter logic [PC_W-1:0] ALT_BOOT_PC  = '0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_THR-1:0]           we_i,
  input  logic [PC_W-1:0]              pc_i,
  output logic [NUM_THR-1:0][PC_W-1:0] saved_o
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_ctx
    localparam logic [PC_W-1:0] BOOT = (t == PREF_TID) ? PREF_BOOT_PC : ALT_BOOT_PC;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    saved_o[t] <= BOOT;
      else if (we_i[t]) saved_o[t] <= pc_i;
    end
  end
endmodule

// File: rtl/cgmt_sched.sv
module cgmt_sched
  import cgmt_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PREF_TID = 0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_THR-1:0]           pend_next_i,
  input  logic [NUM_THR-1:0][PC_W-1:0] saved_i,
  output tid_t                         active_tid_o,
  output logic                         flush_o,
  output logic                         redirect_valid_o,
  output logic [PC_W-1:0]              redirect_pc_o
);
  localparam tid_t PREF = tid_t'(PREF_TID);
  localparam tid_t ALT  = tid_t'(1 - PREF_TID);

  tid_t want;
  logic do_switch;

  always_comb begin
    if (!pend_next_i[PREF])     want = PREF;
    else if (!pend_next_i[ALT]) want = ALT;
    else                        want = active_tid_o; // both stalled: hold
  end
  assign do_switch = want != active_tid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_tid_o     <= PREF;
      flush_o          <= 1'b0;
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
    end else begin
      flush_o          <= do_switch;
      redirect_valid_o <= do_switch;
      if (do_switch) begin
        active_tid_o  <= want;
        redirect_pc_o <= saved_i[want];
      end
    end
  end

  p_to_alt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_tid_o == PREF && pend_next_i[PREF] && !pend_next_i[ALT])
      |=> (active_tid_o == ALT && flush_o));
  p_back_pref_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_tid_o != PREF && !pend_next_i[PREF]) |=> (active_tid_o == PREF && redirect_valid_o));
  p_flush_on_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_tid_o) |-> (flush_o && redirect_valid_o));
  p_quiet_no_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !$stable(active_tid_o));
  p_both_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&pend_next_i) |=> (!flush_o && $stable(active_tid_o)));
endmodule

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl
  import cgmt_pkg::*;
#(
  parameter int unsigned     PC_W         = 32,
  parameter int unsigned     PREF_TID     = 0,
  parameter logic [PC_W-1:0] PREF_BOOT_PC = 32'h0000_0000,
  parameter logic [PC_W-1:0] ALT_BOOT_PC  = 32'h0000_2000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            miss_valid_i,
  input  logic            miss_tid_i,
  input  logic [PC_W-1:0] miss_pc_i,
  input  logic            ret_valid_i,
  input  logic            ret_tid_i,
  output logic            active_tid_o,
  output logic            flush_o,
  output logic            redirect_valid_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  logic [NUM_THR-1:0]           pend_next;
  logic [NUM_THR-1:0]           miss_take;
  logic [NUM_THR-1:0][PC_W-1:0] saved_pc;
  tid_t                         active_tid;

  assign active_tid_o = active_tid;

  cgmt_miss_track u_track (
    .clk_i, .rst_ni,
    .miss_valid_i, .miss_tid_i (tid_t'(miss_tid_i)),
    .ret_valid_i,  .ret_tid_i  (tid_t'(ret_tid_i)),
    .active_tid_i (active_tid),
    .pend_next_o  (pend_next),
    .miss_take_o  (miss_take)
  );

  cgmt_ctx_pc #(
    .PC_W(PC_W), .PREF_TID(PREF_TID),
    .PREF_BOOT_PC(PREF_BOOT_PC), .ALT_BOOT_PC(ALT_BOOT_PC)
  ) u_ctx (
    .clk_i, .rst_ni,
    .we_i    (miss_take),
    .pc_i    (miss_pc_i),
    .saved_o (saved_pc)
  );

  cgmt_sched #(.PC_W(PC_W), .PREF_TID(PREF_TID)) u_sched (
    .clk_i, .rst_ni,
    .pend_next_i      (pend_next),
    .saved_i          (saved_pc),
    .active_tid_o     (active_tid),
    .flush_o,
    .redirect_valid_o,
    .redirect_pc_o
  );

  p_stray_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_tid_i != active_tid && !ret_valid_i) |=> !flush_o);
endmodule

// File: tb/sim_cgmt_switch_ctrl.sv
module sim_cgmt_switch_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_v = 1'b0, miss_t = 1'b0, ret_v = 1'b0, ret_t = 1'b0;
  logic [31:0] miss_pc = '0;
  logic act, fl, rv;
  logic [31:0] rpc;
  int checks = 0, errors = 0;
  bit  done = 1'b0;

  typedef struct {
    string       tag;
    logic        act;
    logic        fl;
    logic [31:0] pc;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  cgmt_switch_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_v), .miss_tid_i(miss_t), .miss_pc_i(miss_pc),
    .ret_valid_i(ret_v), .ret_tid_i(ret_t),
    .active_tid_o(act), .flush_o(fl), .redirect_valid_o(rv), .redirect_pc_o(rpc)
  );

  task automatic chk(string tag, logic a, logic f, logic [31:0] pc);
    checks++;
    if (act !== a || fl !== f || rv !== f || (f && rpc !== pc)) begin
      errors++;
      $display("FAIL %s: act=%0d flush=%0d rv=%0d pc=%h exp act=%0d flush=%0d pc=%h",
               tag, act, fl, rv, rpc, a, f, pc);
    end
  endtask

  // driver: one event per cycle, expected result queued for the monitor
  task automatic step(string tag, logic mv, logic mt, logic [31:0] mp,
                      logic r, logic rt, logic ea, logic ef, logic [31:0] ep);
    exp_t e;
    @(negedge clk);
    miss_v = mv; miss_t = mt; miss_pc = mp; ret_v = r; ret_t = rt;
    @(posedge clk);
    e.tag = tag; e.act = ea; e.fl = ef; e.pc = ep;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, e.act, e.fl, e.pc);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d expected run to end", act);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk("R1 reset", 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    step("R4 idle",            0,0,0,          0,0, 0,0,0);
    step("R8 miss inactive",   1,1,32'h2100,   0,0, 0,0,0);
    step("R2 R9 pref miss",    1,0,32'h100,    0,0, 1,1,32'h2000);
    step("R4 no repeat flush", 0,0,0,          0,0, 1,0,0);
    step("R8 dup pref miss",   1,0,32'h900,    0,0, 1,0,0);
    step("R3 pref return",     0,0,0,          1,0, 0,1,32'h100);
    step("R5 alt pc kept",     1,0,32'h140,    0,0, 1,1,32'h2000);
    step("R6 alt miss hold",   1,1,32'h2040,   0,0, 1,0,0);
    step("R6 both pending",    0,0,0,          0,0, 1,0,0);
    step("R3 return w/ alt pend",0,0,0,        1,0, 0,1,32'h140);
    step("R6 pref miss hold",  1,0,32'h180,    0,0, 0,0,0);
    step("R5 alt return",      0,0,0,          1,1, 1,1,32'h2040);
    step("R3 R5 pref back",    0,0,0,          1,0, 0,1,32'h180);
    step("R8 miss inactive 2", 1,1,32'h3000,   0,0, 0,0,0);
    step("R2 pref miss 2",     1,0,32'h1c0,    0,0, 1,1,32'h2040);
    step("R6 alt miss 2",      1,1,32'h2080,   0,0, 1,0,0);
    step("R3 pref return 2",   0,0,0,          1,0, 0,1,32'h1c0);
    step("R7 ret then miss",   1,0,32'h200,    1,1, 1,1,32'h2080);
    step("R5 pref back 3",     0,0,0,          1,0, 0,1,32'h200);
    step("R4 idle end",        0,0,0,          0,0, 0,0,0);
    @(negedge clk);
    miss_v = 0; ret_v = 0;
    @(negedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d left, expected 0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule